// File: doc/BRIEF.md
# Twelve-bit character word packer

This block sits between a channel that moves 12-bit characters and a word store of 24-bit words behind a head-per-track disk. Each storage word carries two characters. The even character is in the upper half and the odd character is in the lower half. A neighbouring sequencer supplies the current disk address (sector number) and a sector byte pointer. The packer turns each read strobe into one character taken from the right half of the addressed word. It turns each write strobe into an update of that word.

Each access is checked against a storage capacity limit and against an 8-bit per-logical-unit write-protect mask. Both are inputs sampled on every access. A failing access is not carried out. Instead the block raises a one-cycle termination pulse that means error, end of record and channel disconnect, and it sets a sticky error latch. The block also keeps the transfer-request flag that the timing logic raises. It answers skip tests for readiness, a clear error latch and an unprotected current unit.

Top module: `char_word_packer`

## Requirements
- R1: After reset, `rd_valid`, `term_abort` and `xfer_req` are 0 and the error latch is clear, so skip code 4 reports true.
- R2: The word address is `disk_addr*64 + (byte_ptr>>1)`. The character index is even when `byte_ptr[0]=0` and odd when it is 1. A read returns bits 23:12 for an even index and bits 11:0 for an odd index, with `rd_valid` high for exactly the one cycle after the strobe cycle.
- R3: A write with an even index stores the character in bits 23:12 and clears bits 11:0 of the word.
- R4: A write with an odd index ORs the character into bits 11:0 and leaves bits 23:12 unchanged.
- R5: A read or write whose word address is greater than or equal to `cap_words` leaves storage untouched and gives no `rd_valid`. `term_abort` pulses for one cycle in the cycle after the strobe, and the error latch becomes set.
- R6: The logical unit is `disk_addr>>12`. A write to a unit whose bit in `wp_mask` is 1 behaves as in R5. A read from such a unit proceeds normally.
- R7: `xfer_req` rises the cycle after `xfer_set` and falls the cycle after any read or write strobe. When `xfer_set` and a strobe coincide, `xfer_req` stays set.
- R8: `skip_ok` combinationally reports one of three conditions. Code 0 (octal 00) means `unit_busy` is low. Code 4 (octal 04) means the error latch is clear. Code 12 (octal 14) means the current unit is not write-protected. Any other code reports 0.
- R9: `conn` clears the error latch on the next edge. A fault in the same cycle as `conn` takes precedence and leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conn | input | 1 | Connect pulse; clears the error latch |
| rd_stb | input | 1 | Read one character |
| wr_stb | input | 1 | Write one character |
| disk_addr | input | 15 | Current sector address from the sequencer |
| byte_ptr | input | 7 | Character index within the sector |
| wr_char | input | 12 | Character to write |
| wp_mask | input | 8 | Write-protect bit per logical unit |
| cap_words | input | 21 | Number of words in storage |
| unit_busy | input | 1 | Rotational timing reports an operation in progress |
| xfer_set | input | 1 | Timing logic requests the next transfer |
| skip_cond | input | 6 | Skip-test condition code |
| rd_valid | output | 1 | `rd_char` holds a read result |
| rd_char | output | 12 | Character read |
| term_abort | output | 1 | Error, end-of-record and disconnect pulse |
| xfer_req | output | 1 | Pending transfer request |
| skip_ok | output | 1 | Result of the selected skip test |

## Verification
The assertions assume that the channel never raises `rd_stb` and `wr_stb` together. They also assume that every strobe is followed by at least one idle cycle, because an odd-character write spends that cycle writing back the merged word on the single storage port. The bench drives every access through one task. That task raises a single strobe for one cycle and then holds both strobes low for a full cycle, so the stimulus always stays within the assumptions. Capacity and protection inputs are changed only between accesses.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  localparam logic [5:0] SKIP_READY  = 6'o00;
  localparam logic [5:0] SKIP_NOERR  = 6'o04;
  localparam logic [5:0] SKIP_NOPROT = 6'o14;

endpackage

// File: rtl/cwp_locate.sv
module cwp_locate #(
  parameter int DA_W          = 15,
  parameter int PTR_W         = 7,
  parameter int WORDS_PER_SEC = 64,
  parameter int LU_SHIFT      = 12,
  parameter int NUM_LU        = 8,
  parameter int RAM_AW        = 8,
  localparam int WA_W         = DA_W + $clog2(WORDS_PER_SEC),
  localparam int LU_W         = $clog2(NUM_LU)
) (
  input  logic [DA_W-1:0]   disk_addr,
  input  logic [PTR_W-1:0]  byte_ptr,
  input  logic [WA_W-1:0]   cap_words,
  input  logic [NUM_LU-1:0] wp_mask,
  output logic [RAM_AW-1:0] ram_index,
  output logic              odd_char,
  output logic [LU_W-1:0]   lun,
  output logic              beyond_cap,
  output logic              lu_locked
);

  logic [WA_W-1:0] word_addr;

  always_comb begin
    word_addr  = WA_W'(disk_addr) * WA_W'(WORDS_PER_SEC) + WA_W'(byte_ptr >> 1);
    ram_index  = word_addr[RAM_AW-1:0];
    odd_char   = byte_ptr[0];
    lun        = LU_W'(disk_addr >> LU_SHIFT);
    beyond_cap = (word_addr >= cap_words);
    lu_locked  = wp_mask[lun];
  end

endmodule

// File: rtl/cwp_merge.sv
module cwp_merge #(
  parameter int CHAR_W = 12,
  localparam int WORD_W = 2 * CHAR_W
) (
  input  logic [WORD_W-1:0] old_word,
  input  logic [CHAR_W-1:0] chr,
  input  logic              odd_char,
  output logic [WORD_W-1:0] new_word,
  output logic [CHAR_W-1:0] pick_char
);

  always_comb begin
    if (odd_char) begin
      new_word  = old_word | {{CHAR_W{1'b0}}, chr};
      pick_char = old_word[CHAR_W-1:0];
    end else begin
      new_word  = {chr, {CHAR_W{1'b0}}};
      pick_char = old_word[WORD_W-1:CHAR_W];
    end
  end

endmodule

// File: rtl/cwp_word_ram.sv
module cwp_word_ram #(
  parameter int AW = 8,
  parameter int DW = 24,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[addr] <= wdata;
      end else begin
        rdata <= mem[addr];
      end
    end
  end

endmodule

// File: rtl/char_word_packer.sv
module char_word_packer
  import cwp_pkg::*;
#(
  parameter int CHAR_W        = 12,
  parameter int WORDS_PER_SEC = 64,
  parameter int SEC_PER_LU    = 4096,
  parameter int NUM_LU        = 8,
  parameter int RAM_AW        = 8,
  localparam int PTR_W        = $clog2(2 * WORDS_PER_SEC),
  localparam int LU_SHIFT     = $clog2(SEC_PER_LU),
  localparam int LU_W         = $clog2(NUM_LU),
  localparam int DA_W         = LU_SHIFT + LU_W,
  localparam int WA_W         = DA_W + $clog2(WORDS_PER_SEC),
  localparam int WORD_W       = 2 * CHAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conn,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DA_W-1:0]   disk_addr,
  input  logic [PTR_W-1:0]  byte_ptr,
  input  logic [CHAR_W-1:0] wr_char,
  input  logic [NUM_LU-1:0] wp_mask,
  input  logic [WA_W-1:0]   cap_words,
  input  logic              unit_busy,
  input  logic              xfer_set,
  input  logic [5:0]        skip_cond,
  output logic              rd_valid,
  output logic [CHAR_W-1:0] rd_char,
  output logic              term_abort,
  output logic              xfer_req,
  output logic              skip_ok
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  // address decode and checks
  logic [RAM_AW-1:0] loc_index;
  logic              loc_odd;
  logic [LU_W-1:0]   loc_lun;
  logic              beyond_cap;
  logic              lu_locked;

  cwp_locate #(
    .DA_W(DA_W), .PTR_W(PTR_W), .WORDS_PER_SEC(WORDS_PER_SEC),
    .LU_SHIFT(LU_SHIFT), .NUM_LU(NUM_LU), .RAM_AW(RAM_AW)
  ) u_locate (
    .disk_addr (disk_addr),
    .byte_ptr  (byte_ptr),
    .cap_words (cap_words),
    .wp_mask   (wp_mask),
    .ram_index (loc_index),
    .odd_char  (loc_odd),
    .lun       (loc_lun),
    .beyond_cap(beyond_cap),
    .lu_locked (lu_locked)
  );

  // control state
  acc_e              kind_now, kind_d, kind_q;
  logic              fault_now, go_now;
  logic              abort_d, abort_q;
  logic              err_d, err_q;
  logic              xfer_d, xfer_q;
  logic [RAM_AW-1:0] stg_index_q;
  logic              stg_odd_q;
  logic [CHAR_W-1:0] stg_char_q;

  always_comb begin
    kind_now = ACC_IDLE;
    if (rd_stb)      kind_now = ACC_READ;
    else if (wr_stb) kind_now = ACC_WRITE;

    fault_now = (kind_now != ACC_IDLE) &&
                (beyond_cap || ((kind_now == ACC_WRITE) && lu_locked));
    go_now    = (kind_now != ACC_IDLE) && !fault_now;

    kind_d  = go_now ? kind_now : ACC_IDLE;
    abort_d = fault_now;

    err_d = err_q;
    if (conn)      err_d = 1'b0;
    if (fault_now) err_d = 1'b1;

    xfer_d = xfer_q;
    if (kind_now != ACC_IDLE) xfer_d = 1'b0;
    if (xfer_set)             xfer_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      kind_q  <= ACC_IDLE;
      abort_q <= 1'b0;
      err_q   <= 1'b0;
      xfer_q  <= 1'b0;
    end else begin
      kind_q  <= kind_d;
      abort_q <= abort_d;
      err_q   <= err_d;
      xfer_q  <= xfer_d;
    end
  end

  // staged access details, loaded only when an access proceeds
  always_ff @(posedge clk) begin
    if (go_now) begin
      stg_index_q <= loc_index;
      stg_odd_q   <= loc_odd;
      stg_char_q  <= wr_char;
    end
  end

  // storage port: read on the strobe edge, merged write on the next edge
  logic              ram_en, ram_we;
  logic [RAM_AW-1:0] ram_addr;
  logic [WORD_W-1:0] ram_rdata, ram_wdata;
  logic [CHAR_W-1:0] pick_char;

  always_comb begin
    ram_we   = (kind_q == ACC_WRITE);
    ram_en   = go_now || ram_we;
    ram_addr = ram_we ? stg_index_q : loc_index;
  end

  cwp_merge #(.CHAR_W(CHAR_W)) u_merge (
    .old_word (ram_rdata),
    .chr      (stg_char_q),
    .odd_char (stg_odd_q),
    .new_word (ram_wdata),
    .pick_char(pick_char)
  );

  cwp_word_ram #(.AW(RAM_AW), .DW(WORD_W)) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .rdata(ram_rdata)
  );

  // outputs
  always_comb begin
    rd_valid   = (kind_q == ACC_READ);
    rd_char    = pick_char;
    term_abort = abort_q;
    xfer_req   = xfer_q;
    skip_ok    = 1'b0;
    if (skip_cond == SKIP_READY)  skip_ok = !unit_busy;
    if (skip_cond == SKIP_NOERR)  skip_ok = !err_q;
    if (skip_cond == SKIP_NOPROT) skip_ok = !lu_locked;
  end

  // assertions
  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(rd_stb && wr_stb)); // R2
  AST_STB_SPACING: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_stb || wr_stb) |=> !(rd_stb || wr_stb)); // R4
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_s_n)
    rd_valid |-> $past(rd_stb)); // R2
  AST_WRITE_LATENCY: assert property (@(posedge clk) disable iff (!rst_s_n)
    ram_we |-> $past(wr_stb)); // R3
  AST_ABORT_LATCHES: assert property (@(posedge clk) disable iff (!rst_s_n)
    term_abort |-> err_q); // R5
  AST_ABORT_NO_DATA: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(term_abort && rd_valid)); // R5
  AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_stb && lu_locked) |=> (!ram_we && term_abort)); // R6
  AST_XFER_CLEARED: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((rd_stb || wr_stb) && !xfer_set) |=> !xfer_req); // R7
  AST_CONN_CLEARS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (conn && !rd_stb && !wr_stb) |=> !err_q); // R9

endmodule

// File: tb/char_word_packer_test.sv
module char_word_packer_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        conn, rd_stb, wr_stb, unit_busy, xfer_set;
  logic [14:0] disk_addr;
  logic [6:0]  byte_ptr;
  logic [11:0] wr_char;
  logic [7:0]  wp_mask;
  logic [20:0] cap_words;
  logic [5:0]  skip_cond;
  logic        rd_valid, term_abort, xfer_req, skip_ok;
  logic [11:0] rd_char;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit          abort;
    logic [11:0] val;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  logic [23:0] model [256];

  always #5 clk = ~clk;

  char_word_packer uut (
    .clk(clk), .rst_n(rst_n), .conn(conn), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .disk_addr(disk_addr), .byte_ptr(byte_ptr), .wr_char(wr_char),
    .wp_mask(wp_mask), .cap_words(cap_words), .unit_busy(unit_busy),
    .xfer_set(xfer_set), .skip_cond(skip_cond), .rd_valid(rd_valid),
    .rd_char(rd_char), .term_abort(term_abort), .xfer_req(xfer_req),
    .skip_ok(skip_ok)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per produced result
  always @(negedge clk) begin
    if (rst_n && (rd_valid || term_abort)) begin
      checks++;
      if (sbq.size() == 0) begin
        errors++;
        $display("FAIL unexpected output: actual valid=%0b abort=%0b expected none",
                 rd_valid, term_abort);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        if (term_abort !== e.abort || rd_valid !== !e.abort ||
            (!e.abort && rd_char !== e.val)) begin
          errors++;
          $display("FAIL %s: actual abort=%0b char=%03h expected abort=%0b char=%03h",
                   e.tag, term_abort, rd_char, e.abort, e.val);
        end
      end
    end
  end

  task automatic push_exp(input bit wr, input int da, input int ptr,
                          input logic [11:0] ch, input string tag);
    exp_t e;
    int   addr;
    int   idx;
    bit   fault;
    addr  = da * 64 + ptr / 2;
    idx   = addr % 256;
    fault = (addr >= int'(cap_words)) || (wr && wp_mask[da >> 12]);
    e.abort = fault;
    e.tag   = tag;
    e.val   = 12'h000;
    if (!fault) begin
      if (wr) begin
        if (ptr % 2 == 1) model[idx] = model[idx] | {12'h000, ch};
        else              model[idx] = {ch, 12'h000};
      end else begin
        e.val = (ptr % 2 == 1) ? model[idx][11:0] : model[idx][23:12];
      end
    end
    if (fault || !wr) sbq.push_back(e);
  endtask

  // driver: one strobe cycle then one idle cycle
  task automatic access(input bit wr, input int da, input int ptr,
                        input logic [11:0] ch, input string tag);
    push_exp(wr, da, ptr, ch, tag);
    disk_addr = 15'(da);
    byte_ptr  = 7'(ptr);
    wr_char   = ch;
    rd_stb    = !wr;
    wr_stb    = wr;
    @(negedge clk);
    rd_stb = 1'b0;
    wr_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic skip_chk(input int code, input bit exp, input string tag);
    skip_cond = 6'(code);
    #1;
    chk(skip_ok === exp, tag, int'(skip_ok), int'(exp));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; conn = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
    unit_busy = 1'b0; xfer_set = 1'b0; disk_addr = '0; byte_ptr = '0;
    wr_char = '0; wp_mask = '0; cap_words = 21'd256; skip_cond = 6'o00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(rd_valid === 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    chk(term_abort === 1'b0, "R1 term_abort", int'(term_abort), 0);
    chk(xfer_req === 1'b0, "R1 xfer_req", int'(xfer_req), 0);
    skip_chk(4, 1'b1, "R1 error latch clear");

    // R2/R3 even write then both halves
    access(1'b1, 1, 4, 12'hABC, "R3 write even");
    access(1'b0, 1, 4, 12'h000, "R2 read even");
    access(1'b0, 1, 5, 12'h000, "R3 low half cleared");
    // R4 odd writes OR into low half
    access(1'b1, 1, 5, 12'h0F0, "R4 write odd");
    access(1'b1, 1, 5, 12'h00F, "R4 write odd again");
    access(1'b0, 1, 5, 12'h000, "R4 read odd merged");
    access(1'b0, 1, 4, 12'h000, "R4 high half kept");
    // R3 even write clears populated low half
    access(1'b1, 1, 4, 12'h123, "R3 rewrite even");
    access(1'b0, 1, 5, 12'h000, "R3 low cleared again");
    access(1'b0, 1, 4, 12'h000, "R3 read new even");
    // R2 other addresses, last word in storage
    access(1'b1, 3, 126, 12'h555, "R2 write word 255 even");
    access(1'b1, 3, 127, 12'hAAA, "R2 write word 255 odd");
    access(1'b0, 3, 127, 12'h000, "R2 read word 255 odd");
    access(1'b0, 3, 126, 12'h000, "R2 read word 255 even");
    access(1'b1, 0, 0, 12'h777, "R2 write word 0");
    access(1'b0, 0, 0, 12'h000, "R2 read word 0");

    // R5 capacity
    access(1'b1, 3, 16, 12'h321, "R5 write word 200 in range");
    access(1'b1, 3, 14, 12'h246, "R5 write word 199");
    cap_words = 21'd200;
    access(1'b1, 3, 16, 12'h999, "R5 write at capacity");
    skip_chk(4, 1'b0, "R5 error latch set");
    access(1'b0, 3, 16, 12'h000, "R5 read at capacity");
    access(1'b0, 3, 14, 12'h000, "R5 read just below capacity");
    cap_words = 21'd256;
    access(1'b0, 3, 16, 12'h000, "R5 aborted write left word");

    // R9 connect clears latch; fault wins when coincident
    conn = 1'b1;
    @(negedge clk);
    conn = 1'b0;
    skip_chk(4, 1'b1, "R9 conn clears latch");
    cap_words = 21'd200;
    push_exp(1'b1, 3, 16, 12'h111, "R9 fault with conn");
    disk_addr = 15'd3; byte_ptr = 7'd16; wr_char = 12'h111;
    wr_stb = 1'b1; conn = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; conn = 1'b0;
    skip_chk(4, 1'b0, "R9 fault beats conn");
    @(negedge clk);
    conn = 1'b1;
    @(negedge clk);
    conn = 1'b0;
    skip_chk(4, 1'b1, "R9 conn clears after fault");

    // R6 write protection, unit 3 aliases onto word 5
    cap_words = 21'h1FFFFF;
    access(1'b1, 0, 10, 12'h0AB, "R6 seed word 5");
    wp_mask = 8'h08;
    access(1'b1, 12288, 10, 12'h0CD, "R6 write protected unit");
    access(1'b0, 0, 10, 12'h000, "R6 word unchanged");
    access(1'b0, 12288, 10, 12'h000, "R6 read protected unit allowed");
    disk_addr = 15'd12288;
    skip_chk(12, 1'b0, "R8 unit 3 protected");
    disk_addr = 15'd0;
    skip_chk(12, 1'b1, "R8 unit 0 unprotected");
    wp_mask = 8'hF7;
    access(1'b1, 12288, 10, 12'h0CD, "R6 write unprotected unit");
    access(1'b0, 0, 10, 12'h000, "R6 write landed");
    conn = 1'b1;
    @(negedge clk);
    conn = 1'b0;
    wp_mask = 8'h00;
    cap_words = 21'd256;

    // R8 ready and unknown codes
    unit_busy = 1'b1;
    skip_chk(0, 1'b0, "R8 busy not ready");
    unit_busy = 1'b0;
    skip_chk(0, 1'b1, "R8 idle ready");
    skip_chk(2, 1'b0, "R8 unknown code");
    skip_chk(4, 1'b1, "R8 no error");

    // R7 transfer request
    xfer_set = 1'b1;
    @(negedge clk);
    xfer_set = 1'b0;
    chk(xfer_req === 1'b1, "R7 request raised", int'(xfer_req), 1);
    access(1'b0, 0, 0, 12'h000, "R7 read clears");
    chk(xfer_req === 1'b0, "R7 request cleared", int'(xfer_req), 0);
    push_exp(1'b0, 0, 0, 12'h000, "R7 read with set");
    disk_addr = 15'd0; byte_ptr = 7'd0;
    rd_stb = 1'b1; xfer_set = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0; xfer_set = 1'b0;
    chk(xfer_req === 1'b1, "R7 set wins over strobe", int'(xfer_req), 1);
    @(negedge clk);

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R2 all expected results produced", sbq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule